// File: doc/BRIEF.md
# Ultra DMA Burst End Controller

This block is the host-side sequencer that closes an Ultra DMA burst on an ATA channel. A single-cycle start pulse opens a burst by pulling the active-low acknowledge line low. While the burst runs, every transition of the strobe input marks one 16-bit word on the data input, and each such word is folded into a running CRC-16. The CRC is seeded at the moment the burst opens.

Either side may close the burst. The host closes it when it sees a PIO request to the channel or the last-word pulse. It raises its stop line and then waits for the device to drop its request line. The device closes the burst by dropping its request line itself, and the host answers by raising stop. In both cases the block then waits for the data source to park the strobe high. It then places the CRC on the data bus, raises the acknowledge line one clock later, holds the CRC for that clock, pulses done, and returns to idle.

Top module: `udma_burst_end`

## Requirements
- R1: While reset is held and right after it, `dack_n` is 1, and `stop`, `data_oe` and `done` are 0.
- R2: A `burst_start` pulse in idle pulls `dack_n` low on the next clock, with `stop` still 0.
- R3: The CRC is seeded to 16'h4ABA when the burst opens. For every clock in which `strobe` differs from its value one clock earlier, while the burst is open and before the stop acknowledge, the word on `data_in` is shifted in MSB first with polynomial x^16+x^12+x^5+1 (16'h1021).
- R4: During a burst, a pulse on `pio_req` or `last_word` raises `stop` on the next clock. The block then stays in the stop-request phase, with strobe edges still counted, for as long as `drq` stays 1.
- R5: During a burst with `stop` at 0, `drq` sampled at 0 makes the block raise `stop` on the next clock.
- R6: Once stop has been acknowledged, strobe transitions and `data_in` no longer change the CRC, including the final move of strobe to high.
- R7: After the acknowledge, the block waits until `strobe` is sampled high. On the next clock `data_oe` is 1 and `data_out` carries the CRC, with `dack_n` still 0.
- R8: One clock after the CRC first appears, `dack_n` rises while `data_oe` stays 1 and `data_out` keeps the same CRC, and `done` is 1 for exactly that clock. On the clock after that, `data_oe`, `stop` and `done` are 0 and `dack_n` stays 1.
- R9: `pio_req` and `last_word` pulses in idle, and `burst_start` pulses during a burst, have no effect: the outputs do not change and the CRC is not reseeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Single-cycle pulse that opens a burst |
| pio_req | input | 1 | Single-cycle pulse: PIO cycle issued to this channel |
| last_word | input | 1 | Single-cycle pulse: final data word has been moved |
| drq | input | 1 | Device request line |
| strobe | input | 1 | Data strobe; each transition marks one word |
| data_in | input | 16 | Data word that goes with a strobe transition |
| stop | output | 1 | Host stop line |
| dack_n | output | 1 | Active-low DMA acknowledge |
| data_out | output | 16 | CRC value driven at the end of the burst |
| data_oe | output | 1 | Enable for driving `data_out` onto the bus |
| done | output | 1 | One-cycle pulse when `dack_n` is released |

## Verification
Randomly sized bursts carry random words separated by random idle gaps. Because of the gaps, the bench can tell a CRC that advances per strobe transition from one that advances per clock. Each burst ends through one of three routes: a PIO request, the last-word pulse, or the device dropping its request. On the host routes, extra words are sent after stop rises, which checks that the stop-request phase still counts data. Before the CRC is placed, junk words are toggled in after the acknowledge, which checks that the CRC is frozen at that point. A burst with no words at all must return the seed. Stray start pulses inside a burst, and end pulses while idle, show whether the controller wrongly reseeds or starts a sequence.

// File: rtl/udma_end_pkg.sv
package udma_end_pkg;

  localparam int CRC_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BURST,
    ST_HREQ,
    ST_SWAIT,
    ST_CRC,
    ST_REL
  } term_state_t;

  // One 16-bit word folded into the CRC, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_word(
    input logic [CRC_W-1:0] cur,
    input logic [CRC_W-1:0] word,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = cur;
    for (int b = CRC_W - 1; b >= 0; b--) begin
      fb  = acc[CRC_W-1] ^ word[b];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return acc;
  endfunction

endpackage

// File: rtl/udma_strobe_edge.sv
module udma_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic strobe_edge
);
  logic strobe_q;

  // The strobe idles high between bursts.
  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= strobe;
  end

  assign strobe_edge = strobe ^ strobe_q;

endmodule

// File: rtl/udma_crc16.sv
module udma_crc16
  import udma_end_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'h4ABA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_en,
  input  logic             upd_en,
  input  logic [CRC_W-1:0] word,
  output logic [CRC_W-1:0] crc
);

  always_ff @(posedge clk) begin
    if (!rst_n)       crc <= SEED;
    else if (seed_en) crc <= SEED;
    else if (upd_en)  crc <= crc_fold_word(crc, word, POLY);
  end

  assert_seed_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_en |=> (crc == SEED));

endmodule

// File: rtl/udma_term_fsm.sv
module udma_term_fsm
  import udma_end_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        burst_start,
  input  logic        host_end,
  input  logic        drq,
  input  logic        strobe,
  output term_state_t state,
  output logic        stop,
  output logic        dack_n,
  output logic        data_oe,
  output logic        done,
  output logic        capture_en,
  output logic        seed_en
);
  term_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (burst_start) nxt = ST_BURST;
      ST_BURST: begin
        if (!drq)          nxt = ST_SWAIT;
        else if (host_end) nxt = ST_HREQ;
      end
      ST_HREQ:  if (!drq)  nxt = ST_SWAIT;
      ST_SWAIT: if (strobe) nxt = ST_CRC;
      ST_CRC:   nxt = ST_REL;
      ST_REL:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign dack_n     = (state == ST_IDLE) || (state == ST_REL);
  assign stop       = (state == ST_HREQ) || (state == ST_SWAIT) ||
                      (state == ST_CRC)  || (state == ST_REL);
  assign data_oe    = (state == ST_CRC)  || (state == ST_REL);
  assign done       = (state == ST_REL);
  assign capture_en = (state == ST_BURST) || (state == ST_HREQ);
  assign seed_en    = (state == ST_IDLE) && burst_start;

  assert_open_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && burst_start) |=> (!dack_n && !stop));

  assert_host_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HREQ) && drq) |=> (stop && capture_en));

  assert_device_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BURST) && !drq) |=> (stop && !capture_en));

  assert_crc_before_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack_n) |-> $past(data_oe));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && dack_n && !stop));

endmodule

// File: rtl/udma_burst_end.sv
module udma_burst_end
  import udma_end_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_SEED = 16'h4ABA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             pio_req,
  input  logic             last_word,
  input  logic             drq,
  input  logic             strobe,
  input  logic [CRC_W-1:0] data_in,
  output logic             stop,
  output logic             dack_n,
  output logic [CRC_W-1:0] data_out,
  output logic             data_oe,
  output logic             done
);
  term_state_t      fsm_state;
  logic             host_end;
  logic             strobe_edge;
  logic             capture_en;
  logic             seed_en;
  logic             word_valid;
  logic [CRC_W-1:0] crc_val;

  assign host_end   = pio_req | last_word;
  assign word_valid = capture_en & strobe_edge;

  udma_strobe_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .strobe_edge (strobe_edge)
  );

  udma_term_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .host_end    (host_end),
    .drq         (drq),
    .strobe      (strobe),
    .state       (fsm_state),
    .stop        (stop),
    .dack_n      (dack_n),
    .data_oe     (data_oe),
    .done        (done),
    .capture_en  (capture_en),
    .seed_en     (seed_en)
  );

  udma_crc16 #(
    .POLY (CRC_POLY),
    .SEED (CRC_SEED)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed_en (seed_en),
    .upd_en  (word_valid),
    .word    (data_in),
    .crc     (crc_val)
  );

  assign data_out = data_oe ? crc_val : '0;

  assert_crc_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_SWAIT) |=> $stable(crc_val));

  assert_crc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack_n) |-> (data_oe && $stable(data_out)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsm_state == ST_IDLE) && !burst_start) |=> (dack_n && !stop && !data_oe));

endmodule

// File: tb/udma_burst_end_test.sv
module udma_burst_end_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_start = 1'b0;
  logic        pio_req = 1'b0;
  logic        last_word = 1'b0;
  logic        drq = 1'b1;
  logic        strobe = 1'b1;
  logic [15:0] data_in = '0;
  logic        stop, dack_n, data_oe, done;
  logic [15:0] data_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_crc;

  always #2.5 clk = ~clk;

  udma_burst_end uut (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .pio_req(pio_req),
    .last_word(last_word), .drq(drq), .strobe(strobe), .data_in(data_in),
    .stop(stop), .dack_n(dack_n), .data_out(data_out), .data_oe(data_oe),
    .done(done)
  );

  // Remainder of (crc ^ word) * x^16 modulo x^16+x^12+x^5+1, by long division.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [31:0] r;
    r = {c ^ w, 16'h0000};
    for (int i = 31; i >= 16; i--)
      if (r[i]) r = r ^ (32'h0001_1021 << (i - 16));
    return r[15:0];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [15:0] w);
    data_in = w;
    strobe  = ~strobe;
    tick();
    exp_crc = ref_crc(exp_crc, w);
  endtask

  task automatic send_words(input int n);
    for (int k = 0; k < n; k++) begin
      send_word(16'($urandom));
      if ($urandom_range(0, 2) == 0) begin
        int gap = $urandom_range(1, 3);
        data_in = 16'($urandom);
        for (int g = 0; g < gap; g++) tick();
      end
    end
  endtask

  // route: 0 = PIO request, 1 = last word, 2 = device drops drq
  task automatic run_burst(input int nwords, input int route, input bit stray_start);
    burst_start = 1'b1;
    tick();
    burst_start = 1'b0;
    exp_crc = 16'h4ABA;
    check("R2", "dack_n after start", {31'd0, dack_n}, 32'd0);
    check("R2", "stop after start", {31'd0, stop}, 32'd0);
    send_words(nwords);
    if (stray_start) begin
      burst_start = 1'b1;
      tick();
      burst_start = 1'b0;
      check("R9", "dack_n after stray start", {31'd0, dack_n}, 32'd0);
      send_words(2);
    end
    if (route < 2) begin
      if (route == 0) pio_req = 1'b1; else last_word = 1'b1;
      tick();
      pio_req = 1'b0;
      last_word = 1'b0;
      check("R4", "stop after host end", {31'd0, stop}, 32'd1);
      send_words($urandom_range(0, 3));
      tick();
      check("R4", "stop held while drq high", {31'd0, stop}, 32'd1);
      check("R4", "no crc while drq high", {31'd0, data_oe}, 32'd0);
      drq = 1'b0;
      tick();
    end else begin
      drq = 1'b0;
      tick();
      check("R5", "stop after device end", {31'd0, stop}, 32'd1);
    end
    for (int j = 0; j < 3; j++) begin
      data_in = 16'($urandom);
      strobe  = 1'b0;
      tick();
      check("R6", "no crc while strobe low", {31'd0, data_oe}, 32'd0);
    end
    data_in = 16'($urandom);
    strobe  = 1'b1;
    tick();
    check("R7", "oe on crc phase", {31'd0, data_oe}, 32'd1);
    check("R7", "dack_n low in crc phase", {31'd0, dack_n}, 32'd0);
    check("R3", "crc value", {16'd0, data_out}, {16'd0, exp_crc});
    tick();
    check("R8", "dack_n released", {31'd0, dack_n}, 32'd1);
    check("R8", "done pulse", {31'd0, done}, 32'd1);
    check("R8", "crc held", {15'd0, data_oe, data_out}, {15'd0, 1'b1, exp_crc});
    drq = 1'b1;
    tick();
    check("R8", "idle outputs", {28'd0, dack_n, stop, data_oe, done}, {28'd0, 4'b1000});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick();
    check("R1", "reset outputs", {28'd0, dack_n, stop, data_oe, done}, {28'd0, 4'b1000});
    tick();
    rst_n = 1'b1;
    tick();
    check("R1", "after reset", {28'd0, dack_n, stop, data_oe, done}, {28'd0, 4'b1000});

    pio_req = 1'b1;
    tick();
    pio_req = 1'b0;
    last_word = 1'b1;
    tick();
    last_word = 1'b0;
    check("R9", "end pulses in idle", {30'd0, dack_n, stop}, 32'd2);

    run_burst(0, 1, 1'b0);
    run_burst(5, 0, 1'b0);
    run_burst(4, 2, 1'b0);
    run_burst(6, 1, 1'b1);
    for (int t = 0; t < 30; t++)
      run_burst($urandom_range(0, 20), $urandom_range(0, 2), 1'($urandom_range(0, 1)));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule